// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block is the host-side register file for a PS/2 keyboard or mouse port. Software reaches it through a simple register bus: an address, separate read and write strobes, an access-size code and a byte of write data. On the other side it talks to a byte-stream device port. The receive side is a byte source with an available flag and a pop strobe. The transmit side is a byte output with a one-cycle strobe. Serial line timing and the receive FIFO are outside the block.

The block holds a control byte, a clock-divisor byte, a status byte and two raw interrupt bits, one for receive and one for transmit. Reads return the selected byte, zero-extended and registered, one cycle after the read strobe. A data write is treated as sent at once. The raw transmit bit therefore dips low for one cycle and then returns high. The single level interrupt output follows the OR of the enabled raw bits one clock later. It falls whenever all enabled bits clear, so software sees a drop and a re-assert around every transmit.

Top module: `ps2_host_regs`

## Requirements
- R1: After synchronous reset the outputs are as follows: status reads 0x43, control, clock divisor and interrupt status read 0x00, and irq, bus_err, dev_tx_stb and bus_rdata are low or zero.
- R2: The read/write registers are control at offset 0x000 and clock divisor at offset 0x00C, each 8 bits wide. A read returns the value zero-extended to 32 bits on bus_rdata in the cycle after the read strobe. Writing one of these registers leaves the other unchanged.
- R3: A status read (offset 0x004) returns the stored status byte 0x43 with bit 4 replaced by dev_rx_valid as sampled in the read cycle.
- R4: A data read (offset 0x008) returns dev_rx_byte and pulses dev_rx_pop in the same cycle when dev_rx_valid is high. When dev_rx_valid is low it returns 0 and does not pop.
- R5: The raw receive bit (interrupt bit 0) is loaded from dev_rx_valid on the clock after dev_rx_valid rises. It is loaded again on the clock after every data read.
- R6: A byte write to the data offset presents the low byte on dev_tx_byte and raises dev_tx_stb for exactly one cycle. The same edge clears the raw transmit bit (interrupt bit 1), and the next edge sets it again.
- R7: Interrupt status (offset 0x010) reads bit 0 = raw rx AND control bit 4, and bit 1 = raw tx AND control bit 3. All other bits read 0.
- R8: irq rises one clock after a masked bit becomes pending from none pending, and falls one clock after the last pending masked bit clears. As a result, with tx enabled, irq drops for one cycle after each data write.
- R9: bus_size encodes 0 = byte, 1 = half, 2 = word and 3 = reserved. A write with any size other than byte raises bus_err for one cycle, changes no register and sends no byte.
- R10: Byte writes to unmapped offsets, to status or to interrupt status change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code of the write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | RDATA_W | Registered read data |
| bus_err | output | 1 | One-cycle error for a write that is not a byte write |
| dev_rx_valid | input | 1 | Receive byte available |
| dev_rx_byte | input | 8 | Head receive byte |
| dev_rx_pop | output | 1 | Consume the head receive byte |
| dev_tx_byte | output | 8 | Byte sent to the device |
| dev_tx_stb | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt |

## Verification
A wrong raw interrupt bit shows up as a wrong interrupt-status read on the next access. It also shows on irq one clock after the bit changes. A receive bit that is refreshed at the wrong time leaves irq high after the last byte has been drained, and that is visible two clocks after the final data read. A transmit sequence that is broken shows at once as a missing or stretched strobe, or as an irq that fails to dip in the second cycle after a data write.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
  localparam int unsigned NUM_REGS = 5;

  // byte offsets, indexed by reg_sel_e
  localparam int unsigned REG_OFS [NUM_REGS] = '{32'h00, 32'h04, 32'h08, 32'h0C, 32'h10};

  localparam int unsigned CTRL_RXEN_BIT   = 4;
  localparam int unsigned CTRL_TXEN_BIT   = 3;
  localparam int unsigned INT_RX_BIT      = 0;
  localparam int unsigned INT_TX_BIT      = 1;
  localparam int unsigned STAT_RXFULL_BIT = 4;
  localparam logic [7:0]  STAT_RESET      = 8'h43;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_STAT = 3'd1,
    SEL_DATA = 3'd2,
    SEL_CDIV = 3'd3,
    SEL_ISR  = 3'd4,
    SEL_NONE = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ps2_reg_decode.sv
module ps2_reg_decode
  import ps2_host_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(REG_OFS[i]));
  end

  always_comb begin
    sel = SEL_NONE;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (hit[i]) sel = reg_sel_e'(i);
    end
  end
endmodule

// File: rtl/ps2_irq_ctrl.sv
module ps2_irq_ctrl
  import ps2_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       tx_en,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic       rx_valid,
  output logic [1:0] raw,
  output logic [1:0] masked,
  output logic       irq
);
  logic rx_prev;
  logic rx_refresh;
  logic tx_rearm;
  logic pending;

  always_comb begin
    masked             = '0;
    masked[INT_RX_BIT] = raw[INT_RX_BIT] & rx_en;
    masked[INT_TX_BIT] = raw[INT_TX_BIT] & tx_en;
  end

  assign pending = |masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw        <= '0;
      rx_prev    <= 1'b0;
      rx_refresh <= 1'b0;
      tx_rearm   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      rx_prev    <= rx_valid;
      rx_refresh <= data_rd;
      if ((rx_valid && !rx_prev) || rx_refresh) begin
        raw[INT_RX_BIT] <= rx_valid;
      end
      if (data_wr) begin
        raw[INT_TX_BIT] <= 1'b0;
        tx_rearm        <= 1'b1;
      end else if (tx_rearm) begin
        raw[INT_TX_BIT] <= 1'b1;
        tx_rearm        <= 1'b0;
      end
      if (!irq && pending) begin
        irq <= 1'b1;
      end else if (irq && !pending) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ps2_read_mux.sv
module ps2_read_mux
  import ps2_host_pkg::*;
#(
  parameter int RDATA_W = 32
) (
  input  reg_sel_e           sel,
  input  logic [7:0]         ctrl,
  input  logic [7:0]         cdiv,
  input  logic [7:0]         stat,
  input  logic [1:0]         masked,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  output logic [RDATA_W-1:0] value
);
  localparam int PAD_W = RDATA_W - 8;

  logic [7:0] byte_v;
  logic [7:0] stat_live;

  always_comb begin
    stat_live                  = stat;
    stat_live[STAT_RXFULL_BIT] = rx_valid;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: byte_v = ctrl;
      SEL_STAT: byte_v = stat_live;
      SEL_DATA: byte_v = rx_valid ? rx_byte : 8'h00;
      SEL_CDIV: byte_v = cdiv;
      SEL_ISR:  byte_v = {6'b0, masked};
      default:  byte_v = 8'h00;
    endcase
  end

  assign value = {{PAD_W{1'b0}}, byte_v};
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2_host_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int RDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_size,
  input  logic [7:0]         bus_wdata,
  output logic [RDATA_W-1:0] bus_rdata,
  output logic               bus_err,
  input  logic               dev_rx_valid,
  input  logic [7:0]         dev_rx_byte,
  output logic               dev_rx_pop,
  output logic [7:0]         dev_tx_byte,
  output logic               dev_tx_stb,
  output logic               irq
);
  reg_sel_e           sel;
  logic               wr_ok;
  logic               data_rd;
  logic               data_wr;
  logic [7:0]         ctrl_q;
  logic [7:0]         cdiv_q;
  logic [7:0]         stat_q;
  logic [1:0]         raw_int;
  logic [1:0]         masked_int;
  logic [RDATA_W-1:0] rd_value;

  ps2_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_ok      = bus_wr && (acc_size_e'(bus_size) == SZ_BYTE);
  assign data_wr    = wr_ok && (sel == SEL_DATA);
  assign data_rd    = bus_rd && (sel == SEL_DATA);
  assign dev_rx_pop = data_rd && dev_rx_valid;

  ps2_irq_ctrl u_irq (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (ctrl_q[CTRL_RXEN_BIT]),
    .tx_en    (ctrl_q[CTRL_TXEN_BIT]),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .rx_valid (dev_rx_valid),
    .raw      (raw_int),
    .masked   (masked_int),
    .irq      (irq)
  );

  ps2_read_mux #(.RDATA_W(RDATA_W)) u_rmux (
    .sel      (sel),
    .ctrl     (ctrl_q),
    .cdiv     (cdiv_q),
    .stat     (stat_q),
    .masked   (masked_int),
    .rx_valid (dev_rx_valid),
    .rx_byte  (dev_rx_byte),
    .value    (rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= 8'h00;
      cdiv_q      <= 8'h00;
      stat_q      <= STAT_RESET;
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
      dev_tx_byte <= 8'h00;
      dev_tx_stb  <= 1'b0;
    end else begin
      bus_err    <= bus_wr && !wr_ok;
      dev_tx_stb <= data_wr;
      if (data_wr) dev_tx_byte <= bus_wdata;
      if (wr_ok && sel == SEL_CTRL) ctrl_q <= bus_wdata;
      if (wr_ok && sel == SEL_CDIV) cdiv_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_value;
    end
  end
endmodule

// File: rtl/ps2_host_regs_chk.sv
module ps2_host_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic              bus_err,
  input logic              dev_rx_valid,
  input logic              dev_rx_pop,
  input logic              dev_tx_stb,
  input logic              irq,
  input logic [1:0]        raw_int,
  input logic [1:0]        masked_int
);
  // R9
  err_only_bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_wr && bus_size != 2'd0));

  // R6
  tx_from_data_write_chk: assert property (@(posedge clk) disable iff (rst)
    dev_tx_stb |-> $past(bus_wr && bus_size == 2'd0 && bus_addr == ADDR_W'(8)));

  // R6
  tx_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    dev_tx_stb |=> raw_int[1]);

  // R4
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    dev_rx_pop |-> dev_rx_valid);

  // R8
  irq_rise_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|masked_int));

  // R8
  irq_fall_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(masked_int == 2'b00));
endmodule

bind ps2_host_regs ps2_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_size     (bus_size),
  .bus_err      (bus_err),
  .dev_rx_valid (dev_rx_valid),
  .dev_rx_pop   (dev_rx_pop),
  .dev_tx_stb   (dev_tx_stb),
  .irq          (irq),
  .raw_int      (raw_int),
  .masked_int   (masked_int)
);

// File: tb/ps2_host_regs_tb.sv
module ps2_host_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_DATA = 12'h008,
                          A_CDIV = 12'h00C, A_ISR = 12'h010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, dev_rx_valid, dev_rx_pop, dev_tx_stb, irq;
  logic [7:0]  dev_rx_byte, dev_tx_byte;

  // receive byte source
  logic [7:0] fmem [8];
  logic [2:0] fhead = '0, ftail = '0;
  int npop = 0;
  assign dev_rx_valid = (fhead != ftail);
  assign dev_rx_byte  = fmem[fhead];
  always @(posedge clk) if (dev_rx_pop && dev_rx_valid) begin
    fhead <= fhead + 3'd1;
    npop  <= npop + 1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_regs #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .dev_rx_valid(dev_rx_valid), .dev_rx_byte(dev_rx_byte), .dev_rx_pop(dev_rx_pop),
    .dev_tx_byte(dev_tx_byte), .dev_tx_stb(dev_tx_stb), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [1:0] sz, input logic [7:0] d);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  typedef struct packed {
    logic [11:0] waddr;
    logic [1:0]  wsize;
    logic [7:0]  wdata;
    logic        exp_err;
    logic [11:0] raddr;
    logic [31:0] exp_rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 2'd0, 8'h18, 1'b0, 12'h000, 32'h18, 8'd2},  // R2 control
    '{12'h00C, 2'd0, 8'hA5, 1'b0, 12'h00C, 32'hA5, 8'd2},  // R2 divisor
    '{12'h000, 2'd2, 8'hFF, 1'b1, 12'h000, 32'h18, 8'd9},  // R9 word write
    '{12'h00C, 2'd1, 8'h3C, 1'b1, 12'h00C, 32'hA5, 8'd9},  // R9 half write
    '{12'h014, 2'd0, 8'h77, 1'b0, 12'h014, 32'h00, 8'd10}, // R10 unmapped
    '{12'h004, 2'd0, 8'h00, 1'b0, 12'h004, 32'h43, 8'd10}, // R10 status write
    '{12'h010, 2'd0, 8'hFF, 1'b0, 12'h010, 32'h00, 8'd10}, // R10 isr write
    '{12'h002, 2'd0, 8'h55, 1'b0, 12'h000, 32'h18, 8'd10}, // R10 misaligned
    '{12'h000, 2'd0, 8'h00, 1'b0, 12'h00C, 32'hA5, 8'd2}   // R2 no cross effect
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 err", {31'b0, bus_err}, 0);
    check("R1 stb", {31'b0, dev_tx_stb}, 0);
    check("R1 rdata", bus_rdata, 0);
    do_read(A_STAT, v); check("R1 status", v, 32'h43);
    do_read(A_CTRL, v); check("R1 control", v, 0);
    do_read(A_CDIV, v); check("R1 divisor", v, 0);
    do_read(A_ISR, v);  check("R1 isr", v, 0);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].waddr, VECS[i].wsize, VECS[i].wdata);
      check($sformatf("R%0d err vec%0d", VECS[i].req, i), {31'b0, bus_err}, {31'b0, VECS[i].exp_err});
      check($sformatf("R%0d stb vec%0d", VECS[i].req, i), {31'b0, dev_tx_stb}, 0);
      do_read(VECS[i].raddr, v);
      check($sformatf("R%0d read vec%0d", VECS[i].req, i), v, VECS[i].exp_rd);
      check($sformatf("R%0d err clear vec%0d", VECS[i].req, i), {31'b0, bus_err}, 0);
    end

    // R6 R8 transmit with tx enabled
    do_write(A_CTRL, 2'd0, 8'h08);
    do_write(A_DATA, 2'd0, 8'h5A);
    check("R6 stb", {31'b0, dev_tx_stb}, 1);
    check("R6 byte", {24'b0, dev_tx_byte}, 32'h5A);
    @(negedge clk);
    check("R6 stb one cycle", {31'b0, dev_tx_stb}, 0);
    check("R8 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 irq set", {31'b0, irq}, 1);
    do_read(A_ISR, v); check("R7 isr tx", v, 32'h02);
    do_write(A_DATA, 2'd0, 8'hA7);
    check("R8 irq before dip", {31'b0, irq}, 1);
    @(negedge clk);
    check("R8 irq dip", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 irq back", {31'b0, irq}, 1);

    // R9 bad-size data write sends nothing
    do_write(A_DATA, 2'd2, 8'h11);
    check("R9 data err", {31'b0, bus_err}, 1);
    check("R9 no stb", {31'b0, dev_tx_stb}, 0);
    @(negedge clk);
    check("R9 err one cycle", {31'b0, bus_err}, 0);
    check("R9 irq kept", {31'b0, irq}, 1);

    // R7 R8 masking
    do_write(A_CTRL, 2'd0, 8'h00);
    check("R8 irq lag", {31'b0, irq}, 1);
    @(negedge clk);
    check("R8 irq masked off", {31'b0, irq}, 0);
    do_read(A_ISR, v); check("R7 isr masked", v, 0);

    // R3 R4 R5 receive with rx enabled
    do_write(A_CTRL, 2'd0, 8'h10);
    fmem[ftail] = 8'hC3; fmem[ftail + 3'd1] = 8'h3C; ftail = ftail + 3'd2;
    @(negedge clk);
    check("R5 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R5 irq rx set", {31'b0, irq}, 1);
    do_read(A_ISR, v);  check("R7 isr rx", v, 32'h01);
    do_read(A_STAT, v); check("R3 status full", v, 32'h53);
    do_read(A_DATA, v); check("R4 first byte", v, 32'hC3);
    check("R4 pop count", npop, 1);
    do_read(A_DATA, v); check("R4 second byte", v, 32'h3C);
    check("R5 irq still", {31'b0, irq}, 1);
    @(negedge clk);
    @(negedge clk);
    check("R5 irq drained", {31'b0, irq}, 0);
    do_read(A_DATA, v); check("R4 empty read", v, 0);
    check("R4 no pop", npop, 2);
    do_read(A_STAT, v); check("R3 status empty", v, 32'h43);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule